// File: doc/BRIEF.md
# Bidirectional Segment Clearing Scanner

This block clears one segment of a one-dimensional mine field. The field is a vector of cells. A set bit in the LED vector marks a cell that has not been cleared yet, and a clear bit marks a cell that has. A separate mask marks the cells that hold a mine. When the block receives an activate pulse with a cell index, it captures the mask, the LED vector and the index. It then walks a one-hot pointer away from that cell, first toward higher bit indices and then toward lower ones. At each step it clears the LED bit under the pointer. Each walk stops at the first mine cell or at the end of the field.

The walk is sequential and moves one cell per clock. The controller has five states:
- **S_IDLE** waits for the activate pulse.
- **S_UP** walks toward bit `FIELD_W-1`.
- **S_DOWN** walks toward bit 0.
- **S_DONE_CLEAR** ends a normal scan.
- **S_DONE_MINE** ends a scan whose starting cell was a mine.

The transitions are:
- S_IDLE goes to S_DONE_MINE on activate when the starting cell is a mine.
- S_IDLE goes to S_UP on activate when the starting cell is not a mine.
- S_UP goes to S_DOWN when the next cell is a mine or the pointer is at the top edge. Otherwise it stays in S_UP.
- S_DOWN goes to S_DONE_CLEAR under the same rule at the bottom edge. Otherwise it stays in S_DOWN.
- Both done states return to S_IDLE after one cycle.

The updated vector stays on `led_out` until the next accepted scan. Edge detection on the switches and the surrounding game control live outside this block.

Top module: `seg_clear_scanner`

## Requirements
- R1: While reset is held and after reset is released, `led_out` is all zeros and `done`, `mine_hit` and `busy` are 0.
- R2: An `activate` pulse sampled while `busy` is 0 is accepted. `busy` is 1 from the next cycle up to and including the cycle in which `done` is 1.
- R3: If the mask bit at `sw_idx` is 1, the next cycle shows `done` = 1 and `mine_hit` = 1, and `led_out` equals the captured `led_in` unchanged.
- R4: If the starting cell is not a mine, its LED bit is cleared and `mine_hit` stays 0.
- R5: The upward walk clears each cell at index `sw_idx+1`, `sw_idx+2`, and so on. It stops before the first mine cell, which stays lit, or after clearing bit `FIELD_W-1`.
- R6: After the upward walk, the downward walk restarts at `sw_idx` and clears `sw_idx-1`, `sw_idx-2`, and so on under the same rules, ending at bit 0.
- R7: Mine cells and cells outside the walked segment keep their captured value. A cell that is already 0 does not stop a walk.
- R8: `done` is 1 for exactly one cycle. Let u and d be the numbers of cells cleared upward and downward. For a non-mine start, `done` is 1 in the cycle after the (u+d+3)-th rising edge, where the edge that samples `activate` is the first. For a mine start it is 1 after the first edge.
- R9: An `activate` pulse while `busy` is 1 is ignored. Changes on `sw_idx`, `mine_mask` and `led_in` during a scan do not affect its result.
- R10: `led_out` holds the result of the last scan until the next accepted `activate`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| activate | input | 1 | One-cycle request to start a scan |
| sw_idx | input | IDX_W | Index of the starting cell |
| mine_mask | input | FIELD_W | 1 marks a mine cell |
| led_in | input | FIELD_W | Current LED vector, 1 = not yet cleared |
| led_out | output | FIELD_W | Updated LED vector |
| mine_hit | output | 1 | Starting cell was a mine, valid with `done` |
| done | output | 1 | One-cycle end-of-scan strobe |
| busy | output | 1 | Scan in progress |

## Verification
The hardest case to reach is a second `activate` that arrives in the middle of a walk while the inputs also change. The stimulus therefore starts a scan whose walks last several cycles. Two edges later, it pulses `activate` again with a different index, an inverted mask and an all-ones LED vector. The scoreboard still expects the result and latency of the first scan only. The test set also covers these cases:
- starts at both field edges
- adjacent mines that stop both walks at once
- a two-cell mine
- already-cleared cells inside a segment

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_UP,
        S_DOWN,
        S_DONE_CLEAR,
        S_DONE_MINE
    } scan_state_t;

    typedef enum logic {
        DIR_UP,
        DIR_DOWN
    } walk_dir_t;

endpackage

// File: rtl/scan_probe.sv
module scan_probe
    import scan_pkg::*;
#(
    parameter int FIELD_W = 16
) (
    input  logic [FIELD_W-1:0] ptr,
    input  logic [FIELD_W-1:0] mask,
    input  walk_dir_t          dir,
    output logic [FIELD_W-1:0] nxt_ptr,
    output logic               at_edge,
    output logic               blocked
);

    logic [FIELD_W-1:0] hit_vec;

    always_comb begin
        if (dir == DIR_UP) begin
            nxt_ptr = ptr << 1;
            at_edge = ptr[FIELD_W-1];
        end else begin
            nxt_ptr = ptr >> 1;
            at_edge = ptr[0];
        end
    end

    for (genvar i = 0; i < FIELD_W; i++) begin : g_cell
        assign hit_vec[i] = nxt_ptr[i] & mask[i];
    end

    assign blocked = |hit_vec;

endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      activate,
    input  logic      origin_mine,
    input  logic      at_edge,
    input  logic      blocked,
    output logic      load,
    output logic      step,
    output logic      restart,
    output walk_dir_t dir,
    output logic      busy,
    output logic      done,
    output logic      mine_hit
);

    scan_state_t state_q, state_d;
    logic        stop_walk;

    assign stop_walk = at_edge | blocked;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (activate) state_d = origin_mine ? S_DONE_MINE : S_UP;
            end
            S_UP: begin
                if (stop_walk) state_d = S_DOWN;
            end
            S_DOWN: begin
                if (stop_walk) state_d = S_DONE_CLEAR;
            end
            S_DONE_CLEAR: state_d = S_IDLE;
            S_DONE_MINE:  state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    always_comb begin
        load     = 1'b0;
        step     = 1'b0;
        restart  = 1'b0;
        dir      = DIR_UP;
        busy     = 1'b1;
        done     = 1'b0;
        mine_hit = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                busy = 1'b0;
                load = activate;
            end
            S_UP: begin
                step    = !stop_walk;
                restart = stop_walk;
            end
            S_DOWN: begin
                dir  = DIR_DOWN;
                step = !stop_walk;
            end
            S_DONE_CLEAR: done = 1'b1;
            S_DONE_MINE: begin
                done     = 1'b1;
                mine_hit = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hit_with_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mine_hit |-> done);

    p_down_after_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DOWN) |-> ($past(state_q) == S_UP || $past(state_q) == S_DOWN));

endmodule

// File: rtl/scan_field_reg.sv
module scan_field_reg #(
    parameter int FIELD_W = 16,
    parameter int IDX_W   = $clog2(FIELD_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic               restart,
    input  logic               busy,
    input  logic [IDX_W-1:0]   sw_idx,
    input  logic [FIELD_W-1:0] mask_in,
    input  logic [FIELD_W-1:0] led_in,
    input  logic [FIELD_W-1:0] nxt_ptr,
    output logic [FIELD_W-1:0] ptr_q,
    output logic [FIELD_W-1:0] mask_q,
    output logic [FIELD_W-1:0] led_q
);

    logic [FIELD_W-1:0] origin_q;
    logic [FIELD_W-1:0] origin_oh;

    assign origin_oh = {{(FIELD_W-1){1'b0}}, 1'b1} << sw_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            origin_q <= '0;
            mask_q   <= '0;
            led_q    <= '0;
        end else if (load) begin
            ptr_q    <= origin_oh;
            origin_q <= origin_oh;
            mask_q   <= mask_in;
            led_q    <= ((origin_oh & mask_in) != '0) ? led_in : (led_in & ~origin_oh);
        end else if (step) begin
            ptr_q <= nxt_ptr;
            led_q <= led_q & ~nxt_ptr;
        end else if (restart) begin
            ptr_q <= origin_q;
        end
    end

    p_led_only_falls_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((led_q & ~$past(led_q)) == '0));

    p_mine_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ((($past(led_q) ^ led_q) & mask_q) == '0));

    p_no_reload_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load);

    p_ptr_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(ptr_q) == 1));

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> $stable(led_q));

endmodule

// File: rtl/seg_clear_scanner.sv
module seg_clear_scanner
    import scan_pkg::*;
#(
    parameter  int FIELD_W = 16,
    localparam int IDX_W   = $clog2(FIELD_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               activate,
    input  logic [IDX_W-1:0]   sw_idx,
    input  logic [FIELD_W-1:0] mine_mask,
    input  logic [FIELD_W-1:0] led_in,
    output logic [FIELD_W-1:0] led_out,
    output logic               mine_hit,
    output logic               done,
    output logic               busy
);

    logic               load, step, restart;
    logic               at_edge, blocked;
    walk_dir_t          dir;
    logic [FIELD_W-1:0] ptr_q, mask_q, nxt_ptr;
    logic               origin_mine;

    assign origin_mine = mine_mask[sw_idx];

    scan_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .activate    (activate),
        .origin_mine (origin_mine),
        .at_edge     (at_edge),
        .blocked     (blocked),
        .load        (load),
        .step        (step),
        .restart     (restart),
        .dir         (dir),
        .busy        (busy),
        .done        (done),
        .mine_hit    (mine_hit)
    );

    scan_probe #(.FIELD_W(FIELD_W)) u_probe (
        .ptr     (ptr_q),
        .mask    (mask_q),
        .dir     (dir),
        .nxt_ptr (nxt_ptr),
        .at_edge (at_edge),
        .blocked (blocked)
    );

    scan_field_reg #(.FIELD_W(FIELD_W), .IDX_W(IDX_W)) u_field (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .restart (restart),
        .busy    (busy),
        .sw_idx  (sw_idx),
        .mask_in (mine_mask),
        .led_in  (led_in),
        .nxt_ptr (nxt_ptr),
        .ptr_q   (ptr_q),
        .mask_q  (mask_q),
        .led_q   (led_out)
    );

    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(activate));

endmodule

// File: tb/test_seg_clear_scanner.sv
module test_seg_clear_scanner;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    typedef struct {
        logic [W-1:0] led;
        logic         hit;
        int           lat;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         activate = 1'b0;
    logic [3:0]   sw_idx = '0;
    logic [W-1:0] mine_mask = '0;
    logic [W-1:0] led_in = '0;
    logic [W-1:0] led_out;
    logic         mine_hit, done, busy;

    int   checks = 0;
    int   errors = 0;
    int   edges = 0;
    exp_t sb[$];
    exp_t last;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_clear_scanner #(.FIELD_W(W)) i_seg_clear_scanner (
        .clk(clk), .rst_n(rst_n), .activate(activate), .sw_idx(sw_idx),
        .mine_mask(mine_mask), .led_in(led_in), .led_out(led_out),
        .mine_hit(mine_hit), .done(done), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (activate && !busy) edges <= 1;
        else edges <= edges + 1;
    end

    // Monitor: pops the expected result on each done strobe
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R8 spurious done", 32'(done), 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(led_out == e.led, "R5/R6/R7 led_out", 32'(led_out), 32'(e.led));
                check(mine_hit == e.hit, "R3/R4 mine_hit", 32'(mine_hit), 32'(e.hit));
                check(edges == e.lat, "R8 latency", 32'(edges), 32'(e.lat));
            end
        end
    end

    function automatic exp_t model(int idx, logic [W-1:0] mask, logic [W-1:0] led);
        exp_t r;
        int up = 0;
        int dn = 0;
        r.led = led;
        if (mask[idx]) begin
            r.hit = 1'b1;
            r.lat = 1;
            return r;
        end
        r.hit = 1'b0;
        r.led[idx] = 1'b0;
        for (int j = idx + 1; j < W; j++) begin
            if (mask[j]) break;
            r.led[j] = 1'b0;
            up++;
        end
        for (int j = idx - 1; j >= 0; j--) begin
            if (mask[j]) break;
            r.led[j] = 1'b0;
            dn++;
        end
        r.lat = up + dn + 3;
        return r;
    endfunction

    // Driver: pushes the expectation, pulses activate, optionally disturbs mid-scan
    task automatic run_scan(input int idx, input logic [W-1:0] mask, input logic [W-1:0] led, input bit poke);
        exp_t e;
        e = model(idx, mask, led);
        sb.push_back(e);
        @(negedge clk);
        sw_idx = 4'(idx); mine_mask = mask; led_in = led; activate = 1'b1;
        @(negedge clk);
        activate = 1'b0;
        check(busy == 1'b1, "R2 busy after accept", 32'(busy), 32'd1);
        if (poke) begin
            sw_idx = 4'(W - 1 - idx); mine_mask = ~mask; led_in = '1; activate = 1'b1;
            @(negedge clk);
            activate = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(led_out == e.led, "R10 hold after done", 32'(led_out), 32'(e.led));
        check(busy == 1'b0 && done == 1'b0, "R2 idle after done", {busy, done}, 32'd0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check(led_out == '0 && !done && !mine_hit && !busy, "R1 in reset", {led_out, done, mine_hit, busy}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(led_out == '0 && !done && !mine_hit && !busy, "R1 after reset", {led_out, done, mine_hit, busy}, 32'd0);

        run_scan(5, 16'h0000, 16'hFFFF, 1'b0);   // R5 R6 whole field
        run_scan(5, 16'h0204, 16'hFFFF, 1'b0);   // R5 R6 R7 mines both sides
        run_scan(9, 16'h0200, 16'hABCD, 1'b0);   // R3 start on a mine
        run_scan(15, 16'h0010, 16'hFFFF, 1'b0);  // R5 top edge start
        run_scan(0, 16'h0100, 16'hFFFF, 1'b0);   // R6 bottom edge start
        run_scan(4, 16'h0028, 16'hFFFF, 1'b0);   // R4 adjacent mines
        run_scan(7, 16'h3003, 16'hF0F3, 1'b0);   // R7 unlit cells do not stop
        run_scan(10, 16'h0060, 16'hFFFF, 1'b0);  // R7 two-cell mine below
        run_scan(8, 16'h8001, 16'hFFFF, 1'b1);   // R9 ignored activate mid-scan
        run_scan(3, 16'h0000, 16'h0FF0, 1'b1);   // R9 again, partial LEDs

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule